// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block runs one register access at a time on a parallel ATA device bus at PIO mode 4 speed. A host-side request carries a 5-bit register address, a read/write flag, a byte/word flag and 16-bit write data. From that request the sequencer produces the chip selects, the device address lines, one active-low strobe and the data-bus drive enable. Each of these keeps the bus's minimum address setup, strobe width and recovery times, which are converted from nanoseconds to core clock cycles at elaboration.

While the strobe is low the device can extend the access by holding IORDY low. The sequencer honours that only once the minimum strobe width has elapsed. A wait guard releases the strobe if IORDY never returns. Read data is captured on the clock edge that releases the read strobe, while the device is still driving the bus. The result is returned with a one-cycle done pulse. Requests are taken only while the sequencer is idle.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset and between accesses, both chip selects are high (`ata_cs_n` = 2'b11), `ata_rd_n` and `ata_wr_n` are high, `ata_doe` is 0 and `busy` is 0.
- R2: A request accepted on a rising edge drives `ata_da` = address bits [2:0], `ata_cs_n[0]` = address bit 3 and `ata_cs_n[1]` = address bit 4 from that edge. These stay unchanged until the access ends.
- R3: The strobe (`ata_rd_n` for reads, `ata_wr_n` for writes) goes low exactly ceil(25·CLK_MHZ/1000) cycles after the accepting edge (3 cycles at 100 MHz). The other strobe stays high throughout.
- R4: With IORDY high, the strobe stays low for exactly ceil(70·CLK_MHZ/1000) cycles (7 at 100 MHz).
- R5: IORDY goes through a two-stage synchronizer. If it is low, the strobe stays low until the third rising edge after IORDY goes high, and never for less than the R4 minimum.
- R6: After the strobe rises, address and chip selects hold for ceil(25·CLK_MHZ/1000) cycles (3 at 100 MHz). On the following edge the bus returns to the R1 idle levels and `rsp_done` is high for exactly one cycle.
- R7: On a read, `rsp_rdata` holds `ata_din` as sampled on the edge that releases `ata_rd_n`. A later change of `ata_din` has no effect. For a byte read (`req_byte` = 1), bits [15:8] are zero.
- R8: On a write, `ata_doe` is 1 and `ata_dout` equals the write data from the accepting edge until the done edge. On reads `ata_doe` stays 0. After a write, `rsp_rdata` is zero.
- R9: If IORDY stays low, the strobe is released after R4 minimum plus IORDY_LIMIT cycles. The done pulse then carries `rsp_timeout` = 1 and `rsp_rdata` = 0. Otherwise `rsp_timeout` is 0.
- R10: `busy` is 1 from the accepting edge until the done edge. A `req_valid` seen while busy is ignored: it starts no second access and does not alter the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 5 | [4:3] chip-select levels, [2:0] device register |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_byte | input | 1 | 1 = byte access (read data upper half zeroed) |
| req_wdata | input | DW | Write data |
| busy | output | 1 | An access is in progress |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | DW | Returned read data |
| rsp_timeout | output | 1 | IORDY wait limit hit on the last access |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_da | output | 3 | Device register address |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | DW | Data driven to the device |
| ata_doe | output | 1 | Data bus drive enable |
| ata_din | input | DW | Data from the device |
| ata_iordy | input | 1 | Device ready, low to stretch the strobe |

## Verification
A phase counter that loads or counts wrong shows up in the access itself. Within a few cycles it appears as a setup, strobe or recovery length off by one or more, measured in cycles at the strobe pins. A mis-sequenced state shows as address lines moving mid-access, the wrong strobe, or a second access started by a request made while busy. A wrong capture point appears at the done pulse as returned data that matches the value the bench drives after the strobe rose.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   localparam int ADDR_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_RECOV  = 2'd3
   } seq_state_t;

   // cycles covering at least ns nanoseconds at mhz, rounded up
   function automatic int cyc_from_ns(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ata_pio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];

endmodule

// File: rtl/ata_pio_phase_cnt.sv
module ata_pio_phase_cnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (cnt != 0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R3/R4/R6: once zero, the counter stays there until reloaded
   p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);

endmodule

// File: rtl/ata_pio_wait_guard.sv
module ata_pio_wait_guard #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   output logic expired
);

   if (LIMIT < 0) begin : g_bad_limit
      $error("ata_pio_wait_guard: LIMIT must not be negative");
   end

   if (LIMIT == 0) begin : g_off
      logic unused_in;
      assign unused_in = &{clk, rst_n, waiting};
      assign expired   = 1'b0;
   end else begin : g_on
      localparam int WW = $clog2(LIMIT + 1);
      logic [WW-1:0] wcnt;

      always_ff @(posedge clk) begin
         if (!rst_n || !waiting) wcnt <= '0;
         else if (!expired)      wcnt <= wcnt + 1'b1;
      end

      assign expired = waiting && (wcnt == WW'(LIMIT));

      // R9: the wait count never runs past its limit
      p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wcnt <= WW'(LIMIT));
   end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
   import ata_pio_pkg::*;
#(
   parameter int CLK_MHZ     = 100,
   parameter int DW          = 16,
   parameter int T_SU_NS     = 25,
   parameter int T_ACT_NS    = 70,
   parameter int T_REC_NS    = 25,
   parameter int IORDY_LIMIT = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_byte,
   input  logic [DW-1:0]     req_wdata,
   output logic              busy,
   output logic              rsp_done,
   output logic [DW-1:0]     rsp_rdata,
   output logic              rsp_timeout,
   output logic [1:0]        ata_cs_n,
   output logic [2:0]        ata_da,
   output logic              ata_rd_n,
   output logic              ata_wr_n,
   output logic [DW-1:0]     ata_dout,
   output logic              ata_doe,
   input  logic [DW-1:0]     ata_din,
   input  logic              ata_iordy
);

   localparam int SU_C  = cyc_from_ns(T_SU_NS,  CLK_MHZ);
   localparam int ACT_C = cyc_from_ns(T_ACT_NS, CLK_MHZ);
   localparam int REC_C = cyc_from_ns(T_REC_NS, CLK_MHZ);
   localparam int MAX_C = max3(SU_C, ACT_C, REC_C);
   localparam int CW    = $clog2(MAX_C + 1);
   localparam int AGE_W = 16;

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("ata_pio_seq: CLK_MHZ must be positive");
   end
   if (DW <= 8) begin : g_bad_dw
      $error("ata_pio_seq: DW must exceed 8");
   end
   if (SU_C < 1 || ACT_C < 1 || REC_C < 1) begin : g_bad_times
      $error("ata_pio_seq: every phase needs at least one cycle");
   end

   seq_state_t    st;
   logic          cyc_write, cyc_byte;
   logic          iordy_s;
   logic          ph_load, ph_zero;
   logic [CW-1:0] ph_val;
   logic          waiting, wd_expired;
   logic          release_now;
   logic          strobe_act;

   ata_pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ata_iordy),
      .q     (iordy_s)
   );

   ata_pio_phase_cnt #(.W(CW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .zero     (ph_zero)
   );

   assign waiting = (st == ST_STROBE) && ph_zero && !iordy_s;

   ata_pio_wait_guard #(.LIMIT(IORDY_LIMIT)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (waiting),
      .expired (wd_expired)
   );

   assign release_now = (st == ST_STROBE) && ph_zero && (iordy_s || wd_expired);

   always_comb begin
      ph_load = 1'b0;
      ph_val  = '0;
      unique case (st)
         ST_IDLE: if (req_valid) begin
            ph_load = 1'b1;
            ph_val  = CW'(SU_C - 1);
         end
         ST_SETUP: if (ph_zero) begin
            ph_load = 1'b1;
            ph_val  = CW'(ACT_C - 1);
         end
         ST_STROBE: if (release_now) begin
            ph_load = 1'b1;
            ph_val  = CW'(REC_C - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         cyc_write   <= 1'b0;
         cyc_byte    <= 1'b0;
         ata_cs_n    <= 2'b11;
         ata_da      <= '0;
         ata_rd_n    <= 1'b1;
         ata_wr_n    <= 1'b1;
         ata_doe     <= 1'b0;
         ata_dout    <= '0;
         rsp_done    <= 1'b0;
         rsp_rdata   <= '0;
         rsp_timeout <= 1'b0;
      end else begin
         rsp_done <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               st        <= ST_SETUP;
               cyc_write <= req_write;
               cyc_byte  <= req_byte;
               ata_cs_n  <= req_addr[4:3];
               ata_da    <= req_addr[2:0];
               ata_doe   <= req_write;
               ata_dout  <= req_write ? req_wdata : '0;
            end
            ST_SETUP: if (ph_zero) begin
               st <= ST_STROBE;
               if (cyc_write) ata_wr_n <= 1'b0;
               else           ata_rd_n <= 1'b0;
            end
            ST_STROBE: if (release_now) begin
               st          <= ST_RECOV;
               ata_rd_n    <= 1'b1;
               ata_wr_n    <= 1'b1;
               rsp_timeout <= !iordy_s;
               if (cyc_write || !iordy_s) rsp_rdata <= '0;
               else if (cyc_byte)         rsp_rdata <= {{(DW-8){1'b0}}, ata_din[7:0]};
               else                       rsp_rdata <= ata_din;
            end
            ST_RECOV: if (ph_zero) begin
               st       <= ST_IDLE;
               ata_cs_n <= 2'b11;
               ata_da   <= '0;
               ata_doe  <= 1'b0;
               ata_dout <= '0;
               rsp_done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign strobe_act = !ata_rd_n || !ata_wr_n;

   // checker counters: cycles since acceptance and current strobe length
   logic [AGE_W-1:0] chk_age;
   logic [AGE_W-1:0] chk_low;

   always_ff @(posedge clk) begin
      if (!rst_n || st == ST_IDLE) chk_age <= '0;
      else if (chk_age != '1)      chk_age <= chk_age + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !strobe_act) chk_low <= '0;
      else if (chk_low != '1)    chk_low <= chk_low + 1'b1;
   end

   p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_doe));

   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ata_da) && $stable(ata_cs_n)));

   p_setup_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_act) |-> (chk_age >= AGE_W'(SU_C)));

   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_rd_n && !ata_wr_n));

   p_pulse_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_act) |-> (chk_low >= AGE_W'(ACT_C)));

   p_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_act && !iordy_s && !wd_expired) |=> strobe_act);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_drive_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ata_doe |-> (cyc_write && !ata_rd_n == 1'b0));

   p_dout_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ata_doe && $past(ata_doe)) |-> $stable(ata_dout));

   p_timeout_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_timeout) |-> (rsp_rdata == '0));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !busy);

endmodule

// File: tb/test_ata_pio_seq.sv
module test_ata_pio_seq;

   localparam int DW      = 16;
   localparam int LIMIT   = 40;
   localparam int SU_EXP  = 3;
   localparam int ACT_EXP = 7;
   localparam int REC_EXP = 3;
   localparam int NEVER   = 1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [4:0]    req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_byte = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy, rsp_done, rsp_timeout;
   logic [DW-1:0] rsp_rdata;
   logic [1:0]    ata_cs_n;
   logic [2:0]    ata_da;
   logic          ata_rd_n, ata_wr_n, ata_doe;
   logic [DW-1:0] ata_dout;
   logic [DW-1:0] ata_din = '0;
   logic          ata_iordy = 1'b1;

   int errs = 0;
   int total = 0;

   always #5 clk = ~clk;

   ata_pio_seq #(.CLK_MHZ(100), .DW(DW), .IORDY_LIMIT(LIMIT)) i_ata_pio_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_byte(req_byte), .req_wdata(req_wdata),
      .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
      .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
      .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din), .ata_iordy(ata_iordy)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      total++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic int exp_width(input int nwait);
      int w;
      if (nwait < 0) return ACT_EXP;
      if (nwait >= NEVER) return ACT_EXP + LIMIT;
      w = nwait + 3;
      return (w > ACT_EXP) ? w : ACT_EXP;
   endfunction

   function automatic logic [DW-1:0] exp_data(input bit wr, input bit by,
                                              input logic [DW-1:0] dv, input int nwait);
      if (wr || nwait >= NEVER) return '0;
      if (by) return {8'h00, dv[7:0]};
      return dv;
   endfunction

   function automatic bit bus_match(input logic [4:0] a);
      return (ata_da == a[2:0]) && (ata_cs_n == a[4:3]);
   endfunction

   task automatic run_cycle(input logic [4:0] a, input bit wr, input bit by,
                            input logic [DW-1:0] wd, input logic [DW-1:0] dv,
                            input int nwait, input bit poke);
      int hi, lo, rc;
      bit strobe_ok;
      @(negedge clk);
      req_addr  = a;
      req_write = wr;
      req_byte  = by;
      req_wdata = wd;
      req_valid = 1'b1;
      ata_iordy = (nwait < 0);
      ata_din   = dv;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_wdata = ~wd;
      chk(busy, "R10 busy after accept", busy, 1);
      chk(bus_match(a), "R2 address map", {ata_cs_n, ata_da}, a);
      chk(ata_doe == wr, "R8 drive enable", ata_doe, wr);
      if (wr) chk(ata_dout == wd, "R8 write data", ata_dout, wd);
      hi = 0;
      while (ata_rd_n && ata_wr_n && hi < 200) begin
         hi++;
         @(negedge clk);
      end
      chk(hi == SU_EXP, "R3 setup cycles", hi, SU_EXP);
      strobe_ok = wr ? (!ata_wr_n && ata_rd_n) : (!ata_rd_n && ata_wr_n);
      chk(strobe_ok, "R3 strobe select", {ata_rd_n, ata_wr_n}, wr ? 2'b10 : 2'b01);
      lo = 0;
      while ((!ata_rd_n || !ata_wr_n) && lo < 500) begin
         lo++;
         if (!bus_match(a)) chk(1'b0, "R2 address hold", {ata_cs_n, ata_da}, a);
         if (wr && ata_dout != wd) chk(1'b0, "R8 data hold", ata_dout, wd);
         if (nwait >= 0 && nwait < NEVER && lo == nwait + 1) ata_iordy = 1'b1;
         if (poke && lo == 2) begin
            req_valid = 1'b1;
            req_addr  = a ^ 5'h1f;
         end
         if (poke && lo == 3) req_valid = 1'b0;
         @(negedge clk);
      end
      chk(lo == exp_width(nwait), (nwait < 0) ? "R4 strobe width" :
          (nwait >= NEVER) ? "R9 timeout width" : "R5 stretched width", lo, exp_width(nwait));
      ata_din   = ~dv;
      ata_iordy = 1'b1;
      rc = 0;
      while (!rsp_done && rc < 50) begin
         rc++;
         if (!busy || !bus_match(a)) chk(1'b0, "R6 recovery hold", {busy, ata_cs_n, ata_da}, {1'b1, a});
         @(negedge clk);
      end
      chk(rc == REC_EXP, "R6 recovery cycles", rc, REC_EXP);
      chk(!busy && ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_doe,
          "R6 idle at done", {busy, ata_cs_n, ata_rd_n, ata_wr_n, ata_doe}, 6'b011110);
      chk(rsp_rdata == exp_data(wr, by, dv, nwait), wr ? "R8 write rdata" : "R7 read data",
          rsp_rdata, exp_data(wr, by, dv, nwait));
      chk(rsp_timeout == (nwait >= NEVER), "R9 timeout flag", rsp_timeout, nwait >= NEVER);
      @(negedge clk);
      chk(!rsp_done, "R6 done one cycle", rsp_done, 0);
      if (poke) begin
         @(negedge clk);
         @(negedge clk);
         chk(!busy && ata_cs_n == 2'b11, "R10 request while busy ignored",
             {busy, ata_cs_n}, 3'b011);
      end
   endtask

   initial begin : watchdog
      #1_000_000;
      errs++;
      total++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end

   initial begin : main
      int seed_dummy;
      seed_dummy = $urandom(32'd20240);
      repeat (4) @(negedge clk);
      chk(ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_doe && !busy,
          "R1 reset levels", {ata_cs_n, ata_rd_n, ata_wr_n, ata_doe, busy}, 6'b111100);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_doe && !busy && !rsp_done,
          "R1 idle after reset", {ata_cs_n, ata_rd_n, ata_wr_n, ata_doe, busy}, 6'b111100);

      // directed corner cases
      run_cycle(5'b10_111, 1'b0, 1'b0, 16'h0000, 16'hBEEF, -1, 1'b0);
      run_cycle(5'b01_000, 1'b1, 1'b0, 16'hA55A, 16'h1234, -1, 1'b0);
      run_cycle(5'b00_101, 1'b0, 1'b1, 16'h0000, 16'hC3E7, -1, 1'b0);
      run_cycle(5'b11_010, 1'b0, 1'b0, 16'h0000, 16'h7E81, 0, 1'b0);
      run_cycle(5'b10_001, 1'b0, 1'b0, 16'h0000, 16'h0F0F, 4, 1'b0);
      run_cycle(5'b10_011, 1'b1, 1'b1, 16'h00C4, 16'h5555, 10, 1'b0);
      run_cycle(5'b01_110, 1'b0, 1'b0, 16'h0000, 16'hDEAD, NEVER, 1'b0);
      run_cycle(5'b10_100, 1'b1, 1'b0, 16'h3C3C, 16'h0000, NEVER, 1'b0);
      run_cycle(5'b10_010, 1'b0, 1'b0, 16'h0000, 16'h9876, -1, 1'b1);
      chk(ata_cs_n == 2'b11 && !busy, "R1 idle between accesses", {ata_cs_n, busy}, 3'b110);

      // constrained random accesses
      for (int i = 0; i < 40; i++) begin
         logic [4:0]    a;
         logic [DW-1:0] wd, dv;
         bit            wr, by;
         int            nw;
         a  = 5'($urandom_range(0, 31));
         wr = 1'($urandom_range(0, 1));
         by = 1'($urandom_range(0, 1));
         wd = DW'($urandom);
         dv = DW'($urandom);
         nw = int'($urandom_range(0, 5)) - 1;
         if (nw > 0) nw = int'($urandom_range(0, 30));
         run_cycle(a, wr, by, wd, dv, nw, ($urandom_range(0, 7) == 0));
      end

      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end

endmodule